// File: doc/BRIEF.md
# AXI4-Lite Slave to Register-Bus Bridge

This block sits between an AXI4-Lite master and a bank of registers that use a simple strobe bus. It takes one transaction at a time off the AXI4-Lite channels and replays it on the register side. A write becomes a single-cycle write strobe carrying a word address and the write data. A read becomes a single-cycle read strobe, after which the register bank supplies its data one clock later. The block answers on the matching AXI response channel, always with an OKAY code. It accepts nothing new until the master has taken that response.

A write is taken only when its address and data arrive together. When a write and a read are offered in the same cycle, the write wins and the read waits, still valid, until the write's response handshake completes. The priority is fixed, so a steady stream of writes can hold reads off indefinitely. There is no fairness logic. The block performs no address range check and ignores the protection inputs. The register address is the byte address with its in-word offset bits dropped, truncated to a configurable width of 14 bits by default.

Control is a six-state machine. `ST_IDLE` waits for requests. Taking a write moves it (accept-write) to `ST_WR_STROBE`, which issues the write strobe, and then to `ST_WR_RESP`, which holds the write response until it is taken (write-done) and returns to idle. Taking a read moves it (accept-read) to `ST_RD_STROBE`, which issues the read strobe, and then to `ST_RD_WAIT`, where the register data is captured. It then moves to `ST_RD_RESP`, which holds the read response until it is taken (read-done) and returns to idle.

Top module: `axil_regbus_bridge`

## Requirements
- R1: In the idle state, s_awready and s_wready rise together, in the same cycle as, and only when, s_awvalid and s_wvalid are both high. If only one of the two is high, neither ready rises, and a read offered in that cycle is accepted.
- R2: If a complete write (s_awvalid and s_wvalid) and a read (s_arvalid) are offered in the same idle cycle, only the write is accepted and s_arready stays low. The still-valid read is accepted in the first cycle after the write response handshake.
- R3: After an accept, no new request is accepted until the response handshake completes (s_bvalid&&s_bready or s_rvalid&&s_rready). s_bvalid and s_rvalid stay high until that handshake.
- R4: reg_wr is high for exactly one cycle, the cycle after the write is accepted. In that cycle reg_addr equals byte address bits [REG_AW+1:2] (default [15:2]) and reg_wdata equals the accepted s_wdata. s_bvalid rises in the following cycle.
- R5: reg_rd is high for exactly one cycle, the cycle after the read is accepted, with reg_addr taken from s_araddr as in R4. reg_rdata is sampled one cycle after the strobe, and s_rvalid rises one cycle after that, two cycles after the strobe.
- R6: s_rdata carries the sampled register data and stays stable while s_rvalid is high and s_rready is low, even if reg_rdata changes.
- R7: s_bresp and s_rresp are always 2'b00 (OKAY).
- R8: Every address is served. Address bits above the register address width are dropped without effect, and s_awprot and s_arprot have no effect on any output.
- R9: A synchronous active-low reset returns the block to idle, with s_bvalid, s_rvalid, reg_wr and reg_rd low, even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awprot | input | 3 | Write protection (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arprot | input | 3 | Read protection (ignored) |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | REG_AW | Register word address |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, valid one cycle after reg_rd |

## Verification
The bench targets a write and a read offered in the same cycle. It also holds the write response back while the read waits, checking that the read is neither taken early nor lost after the write completes. A design that accepted both would issue two strobes at once, and one that released the busy state at response issue would accept the read while s_bvalid was still pending. It offers a write address without data alongside a read, where a design that latched half a write would stall the read. It also stalls s_rready while the register bus drives garbage: a bridge that acknowledged in the strobe cycle, or passed reg_rdata straight through, returns the wrong data. Wide addresses, changing protection bits and a reset during an outstanding response cover truncation, the ignored inputs and recovery.

// File: rtl/axil_regbus_pkg.sv
package axil_regbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_STROBE = 3'd1,
        ST_WR_RESP   = 3'd2,
        ST_RD_STROBE = 3'd3,
        ST_RD_WAIT   = 3'd4,
        ST_RD_RESP   = 3'd5
    } bridge_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_regbus_ctrl.sv
module axil_regbus_ctrl
    import axil_regbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic awvalid,
    input  logic wvalid,
    input  logic arvalid,
    input  logic bready,
    input  logic rready,
    output logic awready,
    output logic wready,
    output logic arready,
    output logic bvalid,
    output logic rvalid,
    output logic strobe_wr,
    output logic strobe_rd,
    output logic load_wr,
    output logic load_rd,
    output logic load_rdata
);

    bridge_state_t state_q, state_d;
    logic          wr_req;

    assign wr_req = awvalid && wvalid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req) begin
                    state_d = ST_WR_STROBE;       // accept-write, wins ties
                end else if (arvalid) begin
                    state_d = ST_RD_STROBE;       // accept-read
                end
            end
            ST_WR_STROBE: state_d = ST_WR_RESP;
            ST_WR_RESP:   if (bready) state_d = ST_IDLE;   // write-done
            ST_RD_STROBE: state_d = ST_RD_WAIT;
            ST_RD_WAIT:   state_d = ST_RD_RESP;
            ST_RD_RESP:   if (rready) state_d = ST_IDLE;   // read-done
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        awready    = 1'b0;
        wready     = 1'b0;
        arready    = 1'b0;
        bvalid     = 1'b0;
        rvalid     = 1'b0;
        strobe_wr  = 1'b0;
        strobe_rd  = 1'b0;
        load_rdata = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                awready = wr_req;
                wready  = wr_req;
                arready = arvalid && !wr_req;
            end
            ST_WR_STROBE: strobe_wr  = 1'b1;
            ST_WR_RESP:   bvalid     = 1'b1;
            ST_RD_STROBE: strobe_rd  = 1'b1;
            ST_RD_WAIT:   load_rdata = 1'b1;
            ST_RD_RESP:   rvalid     = 1'b1;
            default: ;
        endcase
    end

    assign load_wr = awready;
    assign load_rd = arready;

endmodule

// File: rtl/axil_regbus_capture.sv
module axil_regbus_capture #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int REG_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic              load_rd,
    input  logic              load_rdata,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic [ADDR_W-1:0] araddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORD_LSB = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] addr_sel;
    logic [REG_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_addr_bits;

    assign addr_sel         = load_wr ? awaddr : araddr;
    assign unused_addr_bits = ^{awaddr, araddr};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load_wr || load_rd) begin
                addr_q <= addr_sel[WORD_LSB +: REG_AW];
            end
            if (load_wr) begin
                wdata_q <= wdata;
            end
            if (load_rdata) begin
                rdata_q <= reg_rdata;
            end
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/axil_regbus_bridge.sv
module axil_regbus_bridge
    import axil_regbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int REG_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [2:0]        s_awprot,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [2:0]        s_arprot,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic load_wr, load_rd, load_rdata;
    logic unused_prot;

    assign unused_prot = ^{s_awprot, s_arprot};

    axil_regbus_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .awvalid    (s_awvalid),
        .wvalid     (s_wvalid),
        .arvalid    (s_arvalid),
        .bready     (s_bready),
        .rready     (s_rready),
        .awready    (s_awready),
        .wready     (s_wready),
        .arready    (s_arready),
        .bvalid     (s_bvalid),
        .rvalid     (s_rvalid),
        .strobe_wr  (reg_wr),
        .strobe_rd  (reg_rd),
        .load_wr    (load_wr),
        .load_rd    (load_rd),
        .load_rdata (load_rdata)
    );

    axil_regbus_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr    (load_wr),
        .load_rd    (load_rd),
        .load_rdata (load_rdata),
        .awaddr     (s_awaddr),
        .araddr     (s_araddr),
        .wdata      (s_wdata),
        .reg_rdata  (reg_rdata),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .rdata      (s_rdata)
    );

    assign s_bresp = RESP_OKAY;
    assign s_rresp = RESP_OKAY;

endmodule

// File: rtl/axil_regbus_bridge_chk.sv
module axil_regbus_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DATA_W-1:0] s_rdata,
    input logic              reg_wr,
    input logic              reg_rd
);

    assert_aw_w_paired_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready |-> (s_wready && s_awvalid && s_wvalid));

    assert_write_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_arready |-> !(s_awvalid && s_wvalid));

    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid || s_rvalid) |-> (!s_awready && !s_arready));

    assert_bvalid_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    assert_wr_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready |=> (reg_wr && !s_bvalid));

    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (!reg_wr && s_bvalid));

    assert_rd_ack_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (!reg_rd && !s_rvalid) ##1 s_rvalid);

    assert_rdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!s_bvalid && !s_rvalid && !reg_wr && !reg_rd));

endmodule

bind axil_regbus_bridge axil_regbus_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .s_rdata   (s_rdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
);

// File: tb/axil_regbus_bridge_tb.sv
`timescale 1ns/1ps
module axil_regbus_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic        s_bready = 1'b0, s_rready = 1'b0;
    logic [19:0] s_awaddr = '0, s_araddr = '0;
    logic [2:0]  s_awprot = '0, s_arprot = '0;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_arready, s_bvalid, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata, reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        reg_wr, reg_rd;
    logic [13:0] reg_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    axil_regbus_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // register bank model: data one clock after the strobe, garbage otherwise
    always @(posedge clk) begin
        reg_rdata <= reg_rd ? (32'hC0DE_0000 | 32'(reg_addr)) : 32'hDEAD_BEEF;
    end

    // vector: [55] write, [54:35] byte address, [34:3] data, [2:0] prot
    localparam int NVEC = 8;
    localparam logic [55:0] VECS [NVEC] = '{
        {1'b1, 20'h00004, 32'h1111_2222, 3'd0},
        {1'b0, 20'h00004, 32'h0,         3'd0},
        {1'b1, 20'hFFFFC, 32'hA5A5_5A5A, 3'd7},
        {1'b0, 20'hF0010, 32'h0,         3'd5},
        {1'b1, 20'h0BEEF, 32'h0000_0001, 3'd2},
        {1'b0, 20'h3FFFC, 32'h0,         3'd7},
        {1'b1, 20'h00000, 32'hFFFF_FFFF, 3'd1},
        {1'b0, 20'h12345, 32'h0,         3'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_exp(input logic [19:0] a);
        return 32'hC0DE_0000 | 32'(a[15:2]);
    endfunction

    // called at the negedge right after the write was seen accepted
    task automatic wr_finish(input logic [19:0] a, input logic [31:0] d, input int hold);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check("R4 strobe", 32'(reg_wr), 32'd1);
        check("R4 addr", 32'(reg_addr), 32'(a[15:2]));
        check("R4 data", reg_wdata, d);
        check("R4 no early bvalid", 32'(s_bvalid), 32'd0);
        @(negedge clk);
        check("R4 single pulse", 32'(reg_wr), 32'd0);
        check("R3 bvalid", 32'(s_bvalid), 32'd1);
        check("R7 bresp", 32'(s_bresp), 32'd0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R3 bvalid held", 32'(s_bvalid), 32'd1);
        end
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        check("R3 bvalid dropped", 32'(s_bvalid), 32'd0);
    endtask

    task automatic rd_finish(input logic [19:0] a, input int hold);
        @(negedge clk);
        s_arvalid = 1'b0;
        check("R5 strobe", 32'(reg_rd), 32'd1);
        check("R5 addr", 32'(reg_addr), 32'(a[15:2]));
        check("R5 no rvalid", 32'(s_rvalid), 32'd0);
        @(negedge clk);
        check("R5 single pulse", 32'(reg_rd), 32'd0);
        check("R5 ack delayed", 32'(s_rvalid), 32'd0);
        @(negedge clk);
        check("R5 rvalid", 32'(s_rvalid), 32'd1);
        check("R5 rdata", s_rdata, rd_exp(a));
        check("R7 rresp", 32'(s_rresp), 32'd0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R6 rvalid held", 32'(s_rvalid), 32'd1);
            check("R6 rdata stable", s_rdata, rd_exp(a));
        end
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
        check("R3 rvalid dropped", 32'(s_rvalid), 32'd0);
    endtask

    task automatic wr_xact(input logic [19:0] a, input logic [31:0] d, input logic [2:0] p, input int hold);
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = a; s_wdata = d; s_awprot = p;
        #1;
        check("R1 awready", 32'(s_awready), 32'd1);
        check("R1 wready", 32'(s_wready), 32'd1);
        wr_finish(a, d, hold);
    endtask

    task automatic rd_xact(input logic [19:0] a, input logic [2:0] p, input int hold);
        @(negedge clk);
        s_arvalid = 1'b1; s_araddr = a; s_arprot = p;
        #1;
        check("R8 arready any address", 32'(s_arready), 32'd1);
        rd_finish(a, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset bvalid", 32'(s_bvalid), 32'd0);
        check("R9 reset rvalid", 32'(s_rvalid), 32'd0);
        check("R9 reset strobes", 32'({reg_wr, reg_rd}), 32'd0);
        rst_n = 1'b1;

        // table walk: R8 wide addresses and prot values
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v][55]) begin
                wr_xact(VECS[v][54:35], VECS[v][34:3], VECS[v][2:0], v % 3);
            end else begin
                rd_xact(VECS[v][54:35], VECS[v][2:0], v % 3);
            end
        end

        // R2: write and read together, write wins, read waits for write-done
        @(negedge clk);
        s_awvalid = 1'b1; s_wvalid = 1'b1; s_awaddr = 20'h00100; s_wdata = 32'h5555_0000;
        s_arvalid = 1'b1; s_araddr = 20'h00200;
        #1;
        check("R2 write taken", 32'(s_awready), 32'd1);
        check("R2 read held", 32'(s_arready), 32'd0);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        check("R2 write strobe", 32'(reg_wr), 32'd1);
        check("R2 no read strobe", 32'(reg_rd), 32'd0);
        check("R2 read still held", 32'(s_arready), 32'd0);
        @(negedge clk);
        check("R3 bvalid", 32'(s_bvalid), 32'd1);
        check("R3 no read accept", 32'(s_arready), 32'd0);
        @(negedge clk);
        check("R3 no read accept while bvalid", 32'(s_arready), 32'd0);
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        check("R2 read taken after write-done", 32'(s_arready), 32'd1);
        rd_finish(20'h00200, 1);

        // R1: address without data does not start a write; a read goes ahead
        @(negedge clk);
        s_awvalid = 1'b1; s_awaddr = 20'h00040; s_wdata = 32'h0000_ABCD;
        #1;
        check("R1 awready without wvalid", 32'(s_awready), 32'd0);
        @(negedge clk);
        check("R1 wready without wvalid", 32'(s_wready), 32'd0);
        s_arvalid = 1'b1; s_araddr = 20'h00044;
        #1;
        check("R1 read with half write", 32'(s_arready), 32'd1);
        rd_finish(20'h00044, 0);
        @(negedge clk);
        s_wvalid = 1'b1;
        #1;
        check("R1 paired accept", 32'(s_awready & s_wready), 32'd1);
        wr_finish(20'h00040, 32'h0000_ABCD, 0);

        // R9: reset while a read response is outstanding
        @(negedge clk);
        s_arvalid = 1'b1; s_araddr = 20'h00080;
        repeat (4) @(negedge clk);
        s_arvalid = 1'b0;
        check("R9 rvalid before reset", 32'(s_rvalid), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 rvalid cleared", 32'(s_rvalid), 32'd0);
        rst_n = 1'b1;
        rd_xact(20'h00088, 3'd0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule